// File: doc/BRIEF.md
# SIMD Instruction Fault Check Unit

This unit decides which architectural fault, if any, a decoded SIMD floating-point arithmetic instruction must take. One request is presented per cycle. It carries the control-register bits that gate SIMD execution, the feature-present flags, the lock-prefix flag and the operand description (register or memory, packed or scalar, single or double precision, address, stack-segment use). It also carries the operating mode, the privilege level, the alignment-check enable, a page-fault flag from the translation logic and the unmasked floating-point exception indication from the datapath.

In the request cycle the unit drives a one-hot vector naming the winning fault. One cycle later it presents a registered fault code together with a one-cycle strobe, and the code is zero when no fault applies. Address translation and segment limit logic live elsewhere. The only memory checks made here are alignment, canonical form in 64-bit mode and the 16-bit offset limit in real and virtual-8086 modes.

Top module: `simd_fault_check`

## Requirements
- R1: Decode invalid-opcode (code 1) is raised when `cr0_em`=1, when `cr4_osfxsr`=0, when `lock_pfx`=1, or when the feature flag for the precision is 0. The flag is `feat_sse2` when `is_double`=1 and `feat_sse` when `is_double`=0.
- R2: Device-not-available (code 2) is raised when `cr0_ts`=1 and no R1 condition holds.
- R3: Memory checks apply only when `mem_op`=1. With a register operand the address, `stack_seg`, `page_fault` and `align_chk_en` have no effect. A packed memory operand whose `addr[3:0]` is not zero raises general-protection (code 3) in every mode.
- R4: In 64-bit mode (`cpu_mode`=3) a memory address whose bits 63 down to 47 are not all equal is non-canonical. It raises stack-fault (code 4) when `stack_seg`=1 and general-protection (code 3) otherwise. The non-canonical outcome takes precedence over the packed-alignment fault.
- R5: In real mode (`cpu_mode`=0) and virtual-8086 mode (`cpu_mode`=2), general-protection (code 3) is raised when `addr[15:0]` plus the operand size minus one exceeds FFFFh. The operand size is 16 bytes for packed, 8 for scalar double and 4 for scalar single.
- R6: `page_fault`=1 with a memory operand raises page fault (code 5).
- R7: Alignment-check (code 6) is raised for a scalar memory operand when `align_chk_en`=1, the address is not a multiple of the size (4 single, 8 double) and the effective privilege level is 3. The effective level is 0 in real mode, 3 in virtual-8086 mode and `cpl` otherwise. A packed operand never raises alignment-check.
- R8: `fp_unmasked`=1 raises the SIMD numeric fault (code 7) when `cr4_osxmmexcpt`=1 and invalid-opcode (code 1) when it is 0.
- R9: Priority from highest to lowest is R1, R2, stack-fault or general-protection, page fault, alignment-check, then R8. `fault_vec` has at most one bit set, with bit 0 UD, 1 NM, 2 GP, 3 SS, 4 PF, 5 AC and 6 XM. It is all zero when `req_valid`=0.
- R10: `code_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. `fault_code` then shows that request's code and 0 when no fault applies. It holds its value while no request arrives. After reset `fault_code`=0 and `code_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Check request present this cycle |
| cr0_em | input | 1 | Emulation control bit |
| cr0_ts | input | 1 | Task-switched control bit |
| cr4_osfxsr | input | 1 | OS support for SIMD state save |
| cr4_osxmmexcpt | input | 1 | OS support for unmasked SIMD numeric faults |
| feat_sse | input | 1 | Single-precision SIMD feature present |
| feat_sse2 | input | 1 | Double-precision SIMD feature present |
| lock_pfx | input | 1 | Lock prefix on the instruction |
| mem_op | input | 1 | Source operand is in memory |
| is_packed | input | 1 | Packed form (1) or scalar form (0) |
| is_double | input | 1 | Double precision (1) or single (0) |
| addr | input | ADDR_W | Memory operand effective address |
| stack_seg | input | 1 | Memory reference uses the stack segment |
| cpu_mode | input | 2 | 0 real, 1 protected/compatibility, 2 virtual-8086, 3 64-bit |
| cpl | input | 2 | Current privilege level |
| align_chk_en | input | 1 | Alignment checking enabled |
| page_fault | input | 1 | Translation reported a page fault |
| fp_unmasked | input | 1 | Datapath raised an unmasked FP exception |
| fault_vec | output | 7 | One-hot winning fault for the current request |
| fault_code | output | 3 | Registered fault code, 0 for none |
| code_valid | output | 1 | Strobe: fault_code belongs to the previous cycle's request |

## Verification
On every cycle, the assertions check that the fault vector is one-hot or empty and idle when no request is present. They also check that the strobe follows each request by exactly one cycle and that the code holds between requests. They further check that a lock prefix always yields invalid-opcode and that the task-switched bit yields device-not-available whenever decode passes. The memory rules, the privilege and mode dependence of alignment-check, the canonical and offset-limit checks, and the full priority order between simultaneous causes are shown only by the bench's directed scenarios. These include the boundary addresses FFF8h and FFF9h and non-canonical addresses combined with misalignment.

// File: rtl/simd_fault_pkg.sv
// Package: shared fault codes, mode encodings and counts for the SIMD
// fault check unit. Assumes codes fit in three bits and 0 means no fault.
package simd_fault_pkg;
    localparam int NUM_FAULTS = 7;
    localparam int CODE_W     = 3;

    typedef enum logic [CODE_W-1:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_GP   = 3'd3,
        FLT_SS   = 3'd4,
        FLT_PF   = 3'd5,
        FLT_AC   = 3'd6,
        FLT_XM   = 3'd7
    } fault_code_e;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2,
        MODE_LONG = 2'd3
    } cpu_mode_e;

    // Bit index in the one-hot vector for a given code (code minus one).
    function automatic int vec_bit(fault_code_e c);
        return int'(c) - 1;
    endfunction
endpackage

// File: rtl/sfc_decode_check.sv
// Decode-stage gate: evaluates the control-register, feature and prefix
// conditions that block execution. Purely combinational; assumes the
// precision flag selects which feature bit applies.
module sfc_decode_check (
    input  logic cr0_em,
    input  logic cr0_ts,
    input  logic cr4_osfxsr,
    input  logic feat_sse,
    input  logic feat_sse2,
    input  logic is_double,
    input  logic lock_pfx,
    output logic ud_hit,
    output logic nm_hit
);
    logic feat_ok;

    // Pick the feature bit for the instruction's precision class.
    always_comb feat_ok = is_double ? feat_sse2 : feat_sse;

    // Raise the blocking conditions; priority is resolved downstream.
    always_comb begin
        ud_hit = cr0_em | ~cr4_osfxsr | ~feat_ok | lock_pfx;
        nm_hit = cr0_ts;
    end
endmodule

// File: rtl/sfc_mem_check.sv
// Memory operand checks: alignment for packed and scalar forms, canonical
// form in 64-bit mode, the 16-bit offset limit in real and virtual-8086
// modes, and page-fault pass-through. Combinational; assumes ADDR_W >= 16
// and VA_BITS <= ADDR_W. All outputs are zero for a register operand.
module sfc_mem_check #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic              mem_op,
    input  logic              is_packed,
    input  logic              is_double,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stack_seg,
    input  logic [1:0]        cpu_mode,
    input  logic [1:0]        cpl,
    input  logic              align_chk_en,
    input  logic              page_fault,
    output logic              gp_hit,
    output logic              ss_hit,
    output logic              pf_hit,
    output logic              ac_hit
);
    import simd_fault_pkg::*;

    localparam int LOW_W = 4;

    logic [LOW_W-1:0] size_mask;
    logic             misaligned;
    logic             non_canon;
    logic [16:0]      end_off;
    logic             mode_long;
    logic             mode_seg16;
    logic [1:0]       cpl_eff;
    logic             addr_unused;

    // Operand size minus one: 16, 8 or 4 bytes.
    always_comb begin
        if (is_packed)      size_mask = 4'hF;
        else if (is_double) size_mask = 4'h7;
        else                size_mask = 4'h3;
    end

    // Natural-alignment test on the low address bits.
    always_comb misaligned = |(addr[LOW_W-1:0] & size_mask);

    // Canonical test: the bits above the virtual width must copy bit VA_BITS-1.
    generate
        if (VA_BITS < ADDR_W) begin : g_canon
            logic [ADDR_W-VA_BITS:0] upper;
            always_comb begin
                upper     = addr[ADDR_W-1:VA_BITS-1];
                non_canon = ~((&upper) | ~(|upper));
            end
        end else begin : g_no_canon
            always_comb non_canon = 1'b0;
        end
    endgenerate

    // Keep otherwise unread address bits visibly consumed.
    always_comb addr_unused = ^addr;

    // Mode decode, last byte offset and effective privilege level.
    always_comb begin
        mode_long  = (cpu_mode == MODE_LONG);
        mode_seg16 = (cpu_mode == MODE_REAL) || (cpu_mode == MODE_V86);
        end_off    = {1'b0, addr[15:0]} + {13'd0, size_mask};
        case (cpu_mode)
            MODE_REAL: cpl_eff = 2'd0;
            MODE_V86:  cpl_eff = 2'd3;
            default:   cpl_eff = cpl;
        endcase
    end

    // Fault conditions; the non-canonical result overrides packed misalignment.
    always_comb begin
        ss_hit = mem_op & mode_long & non_canon & stack_seg;
        gp_hit = mem_op & ~ss_hit &
                 ((mode_long & non_canon) |
                  (is_packed & misaligned) |
                  (mode_seg16 & end_off[16]));
        pf_hit = mem_op & page_fault;
        ac_hit = mem_op & ~is_packed & align_chk_en & misaligned & (cpl_eff == 2'd3);
    end
endmodule

// File: rtl/sfc_prio_sel.sv
// Priority selector: turns the individual fault causes into a one-hot
// vector (bit = code - 1) and its code. Combinational; assumes the causes
// are already qualified by operand kind.
module sfc_prio_sel
    import simd_fault_pkg::*;
#(
    parameter int NF = NUM_FAULTS
) (
    input  logic                req_valid,
    input  logic                ud_hit,
    input  logic                nm_hit,
    input  logic                gp_hit,
    input  logic                ss_hit,
    input  logic                pf_hit,
    input  logic                ac_hit,
    input  logic                fp_unmasked,
    input  logic                cr4_osxmmexcpt,
    output logic [NF-1:0]       vec,
    output logic [CODE_W-1:0]   code
);
    // Highest-priority cause wins; the numeric fault turns into UD without OS support.
    always_comb begin
        vec = '0;
        if (req_valid) begin
            if (ud_hit)           vec[vec_bit(FLT_UD)] = 1'b1;
            else if (nm_hit)      vec[vec_bit(FLT_NM)] = 1'b1;
            else if (ss_hit)      vec[vec_bit(FLT_SS)] = 1'b1;
            else if (gp_hit)      vec[vec_bit(FLT_GP)] = 1'b1;
            else if (pf_hit)      vec[vec_bit(FLT_PF)] = 1'b1;
            else if (ac_hit)      vec[vec_bit(FLT_AC)] = 1'b1;
            else if (fp_unmasked) begin
                if (cr4_osxmmexcpt) vec[vec_bit(FLT_XM)] = 1'b1;
                else                vec[vec_bit(FLT_UD)] = 1'b1;
            end
        end
    end

    // Encode the one-hot vector back into a fault code.
    always_comb begin
        code = FLT_NONE;
        for (int i = 0; i < NF; i++) begin
            if (vec[i]) code = CODE_W'(i + 1);
        end
    end
endmodule

// File: rtl/simd_fault_check.sv
// Top level of the SIMD fault check unit. Combines the decode gate, the
// memory checks and the priority selector, drives the one-hot vector in
// the request cycle and registers the code with a one-cycle strobe.
// Assumes one request per cycle at most; the code holds between requests.
module simd_fault_check
    import simd_fault_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              cr0_em,
    input  logic              cr0_ts,
    input  logic              cr4_osfxsr,
    input  logic              cr4_osxmmexcpt,
    input  logic              feat_sse,
    input  logic              feat_sse2,
    input  logic              lock_pfx,
    input  logic              mem_op,
    input  logic              is_packed,
    input  logic              is_double,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stack_seg,
    input  logic [1:0]        cpu_mode,
    input  logic [1:0]        cpl,
    input  logic              align_chk_en,
    input  logic              page_fault,
    input  logic              fp_unmasked,
    output logic [6:0]        fault_vec,
    output logic [2:0]        fault_code,
    output logic              code_valid
);
    logic ud_hit, nm_hit, gp_hit, ss_hit, pf_hit, ac_hit;
    logic [CODE_W-1:0] sel_code;

    sfc_decode_check u_decode (
        .cr0_em     (cr0_em),
        .cr0_ts     (cr0_ts),
        .cr4_osfxsr (cr4_osfxsr),
        .feat_sse   (feat_sse),
        .feat_sse2  (feat_sse2),
        .is_double  (is_double),
        .lock_pfx   (lock_pfx),
        .ud_hit     (ud_hit),
        .nm_hit     (nm_hit)
    );

    sfc_mem_check #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_mem (
        .mem_op       (mem_op),
        .is_packed    (is_packed),
        .is_double    (is_double),
        .addr         (addr),
        .stack_seg    (stack_seg),
        .cpu_mode     (cpu_mode),
        .cpl          (cpl),
        .align_chk_en (align_chk_en),
        .page_fault   (page_fault),
        .gp_hit       (gp_hit),
        .ss_hit       (ss_hit),
        .pf_hit       (pf_hit),
        .ac_hit       (ac_hit)
    );

    sfc_prio_sel #(.NF(NUM_FAULTS)) u_prio (
        .req_valid      (req_valid),
        .ud_hit         (ud_hit),
        .nm_hit         (nm_hit),
        .gp_hit         (gp_hit),
        .ss_hit         (ss_hit),
        .pf_hit         (pf_hit),
        .ac_hit         (ac_hit),
        .fp_unmasked    (fp_unmasked),
        .cr4_osxmmexcpt (cr4_osxmmexcpt),
        .vec            (fault_vec),
        .code           (sel_code)
    );

    // Capture the winning code on a request and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_code <= FLT_NONE;
            code_valid <= 1'b0;
        end else begin
            code_valid <= req_valid;
            if (req_valid) fault_code <= sel_code;
        end
    end
endmodule

// File: rtl/simd_fault_check_sva.sv
// Checker for simd_fault_check: cycle-level properties of the vector,
// the strobe, the held code and the decode-stage faults. Bound below.
module simd_fault_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       cr0_em,
    input logic       cr0_ts,
    input logic       cr4_osfxsr,
    input logic       feat_sse,
    input logic       feat_sse2,
    input logic       is_double,
    input logic       lock_pfx,
    input logic [6:0] fault_vec,
    input logic [2:0] fault_code,
    input logic       code_valid
);
    logic decode_clear;
    always_comb decode_clear = ~cr0_em & cr4_osfxsr & ~lock_pfx &
                               (is_double ? feat_sse2 : feat_sse);

    // R9: at most one fault bit
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_vec));

    // R9: no vector bits without a request
    p_idle_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (fault_vec == 7'd0));

    // R10: strobe one cycle after a request
    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> code_valid);

    // R10: no strobe without a request
    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !code_valid);

    // R10: code holds while idle
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(fault_code));

    // R1: lock prefix always yields invalid-opcode
    p_lock_ud_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lock_pfx) |=> (fault_code == 3'd1));

    // R2: task-switched yields device-not-available once decode passes
    p_ts_nm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cr0_ts && decode_clear) |=> (fault_code == 3'd2));
endmodule

bind simd_fault_check simd_fault_check_sva chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cr0_em     (cr0_em),
    .cr0_ts     (cr0_ts),
    .cr4_osfxsr (cr4_osfxsr),
    .feat_sse   (feat_sse),
    .feat_sse2  (feat_sse2),
    .is_double  (is_double),
    .lock_pfx   (lock_pfx),
    .fault_vec  (fault_vec),
    .fault_code (fault_code),
    .code_valid (code_valid)
);

// File: tb/simd_fault_check_tb_top.sv
// Scoreboard bench: a driver task computes each request's expected code
// from the requirements and queues it; a monitor pops on every strobe.
module simd_fault_check_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic em, ts, osfxsr, osxmm, sse, sse2, lock;
        logic mem, packed_f, dbl, stk, acen, pf, fpx;
        logic [63:0] a;
        logic [1:0]  mode, cpl;
    } req_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic cr0_em, cr0_ts, cr4_osfxsr, cr4_osxmmexcpt, feat_sse, feat_sse2, lock_pfx;
    logic mem_op, is_packed, is_double, stack_seg, align_chk_en, page_fault, fp_unmasked;
    logic [63:0] addr;
    logic [1:0]  cpu_mode, cpl;
    logic [6:0]  fault_vec;
    logic [2:0]  fault_code;
    logic        code_valid;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic [2:0] last_exp = 3'd0;
    req_t r;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_fault_check dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .cr0_em(cr0_em), .cr0_ts(cr0_ts), .cr4_osfxsr(cr4_osfxsr),
        .cr4_osxmmexcpt(cr4_osxmmexcpt), .feat_sse(feat_sse), .feat_sse2(feat_sse2),
        .lock_pfx(lock_pfx), .mem_op(mem_op), .is_packed(is_packed),
        .is_double(is_double), .addr(addr), .stack_seg(stack_seg),
        .cpu_mode(cpu_mode), .cpl(cpl), .align_chk_en(align_chk_en),
        .page_fault(page_fault), .fp_unmasked(fp_unmasked),
        .fault_vec(fault_vec), .fault_code(fault_code), .code_valid(code_valid)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected code written from the requirement list.
    function automatic logic [2:0] model(req_t q);
        int  sz, ecpl;
        logic canon, mis;
        sz    = q.packed_f ? 16 : (q.dbl ? 8 : 4);
        canon = (q.a[63:47] == 17'd0) || (q.a[63:47] == 17'h1FFFF);
        mis   = (q.a % 64'(sz)) != 0;
        ecpl  = (q.mode == 2'd0) ? 0 : ((q.mode == 2'd2) ? 3 : int'(q.cpl));
        if (q.em || !q.osfxsr || q.lock || !(q.dbl ? q.sse2 : q.sse)) return 3'd1;
        if (q.ts) return 3'd2;
        if (q.mem) begin
            if (q.mode == 2'd3 && !canon) return q.stk ? 3'd4 : 3'd3;
            if (q.packed_f && mis) return 3'd3;
            if ((q.mode == 2'd0 || q.mode == 2'd2) && (int'(q.a[15:0]) + sz - 1 > 65535))
                return 3'd3;
            if (q.pf) return 3'd5;
            if (!q.packed_f && q.acen && mis && ecpl == 3) return 3'd6;
        end
        if (q.fpx) return q.osxmm ? 3'd7 : 3'd1;
        return 3'd0;
    endfunction

    task automatic clean_req();
        r = '{em:0, ts:0, osfxsr:1, osxmm:1, sse:1, sse2:1, lock:0,
              mem:0, packed_f:1, dbl:0, stk:0, acen:0, pf:0, fpx:0,
              a:64'h0, mode:2'd1, cpl:2'd0};
    endtask

    // Driver: apply one request, check the vector, queue the expected code.
    task automatic send(input string tag);
        logic [2:0] e;
        logic [6:0] ev;
        @(negedge clk);
        cr0_em = r.em; cr0_ts = r.ts; cr4_osfxsr = r.osfxsr; cr4_osxmmexcpt = r.osxmm;
        feat_sse = r.sse; feat_sse2 = r.sse2; lock_pfx = r.lock; mem_op = r.mem;
        is_packed = r.packed_f; is_double = r.dbl; addr = r.a; stack_seg = r.stk;
        cpu_mode = r.mode; cpl = r.cpl; align_chk_en = r.acen; page_fault = r.pf;
        fp_unmasked = r.fpx;
        req_valid = 1'b1;
        e  = model(r);
        ev = (e == 3'd0) ? 7'd0 : (7'd1 << (e - 3'd1));
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        #1;
        check(fault_vec == ev, {tag, " R9 vec"}, int'(fault_vec), int'(ev));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check(fault_vec == 7'd0, "R9 idle vec", int'(fault_vec), 0);
        end
    endtask

    // Monitor: pop and compare on every strobe.
    always @(negedge clk) begin
        if (rst_n && code_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected strobe", 1, 0);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(fault_code == e, t, int'(fault_code), int'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clean_req();
        cr0_em = 0; cr0_ts = 0; cr4_osfxsr = 1; cr4_osxmmexcpt = 1; feat_sse = 1;
        feat_sse2 = 1; lock_pfx = 0; mem_op = 0; is_packed = 0; is_double = 0;
        addr = '0; stack_seg = 0; cpu_mode = 2'd1; cpl = 2'd0; align_chk_en = 0;
        page_fault = 0; fp_unmasked = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fault_code == 3'd0, "R10 reset code", int'(fault_code), 0);
        check(code_valid == 1'b0, "R10 reset strobe", int'(code_valid), 0);

        clean_req(); send("R10 no fault");
        clean_req(); r.em = 1; send("R1 emulation");
        clean_req(); r.osfxsr = 0; send("R1 osfxsr clear");
        clean_req(); r.lock = 1; send("R1 lock");
        clean_req(); r.sse = 0; send("R1 sse absent single");
        clean_req(); r.sse = 0; r.dbl = 1; send("R1 sse absent double ok");
        clean_req(); r.sse2 = 0; r.dbl = 1; send("R1 sse2 absent double");
        clean_req(); r.ts = 1; send("R2 task switched");
        clean_req(); r.ts = 1; r.lock = 1; send("R9 UD over NM");
        clean_req(); r.mem = 1; r.a = 64'h1008; send("R3 packed misaligned GP");
        clean_req(); r.mem = 1; r.a = 64'h1010; send("R3 packed aligned");
        clean_req(); r.a = 64'h1003; r.pf = 1; r.stk = 1; r.acen = 1; r.packed_f = 0;
            r.cpl = 3; send("R3 register operand ignores memory");
        clean_req(); r.mode = 3; r.mem = 1; r.a = 64'h0000_8000_0000_0000; send("R4 noncanon GP");
        clean_req(); r.mode = 3; r.mem = 1; r.a = 64'h0000_8000_0000_0000; r.stk = 1;
            send("R4 noncanon SS");
        clean_req(); r.mode = 3; r.mem = 1; r.a = 64'h0000_8000_0000_0004; r.stk = 1;
            send("R4 SS over alignment GP");
        clean_req(); r.mode = 3; r.mem = 1; r.a = 64'hFFFF_8000_0000_0000; send("R4 canonical high");
        clean_req(); r.mode = 0; r.mem = 1; r.packed_f = 0; r.dbl = 1; r.a = 64'hFFF8;
            send("R5 real limit edge ok");
        clean_req(); r.mode = 0; r.mem = 1; r.packed_f = 0; r.dbl = 1; r.a = 64'hFFF9;
            send("R5 real limit GP");
        clean_req(); r.mode = 2; r.mem = 1; r.packed_f = 0; r.a = 64'hFFFD; r.cpl = 0;
            send("R5 v86 limit GP");
        clean_req(); r.mem = 1; r.pf = 1; send("R6 page fault");
        clean_req(); r.mem = 1; r.pf = 1; r.a = 64'h4; send("R9 GP over PF");
        clean_req(); r.mem = 1; r.packed_f = 0; r.a = 64'h2; r.acen = 1; r.cpl = 3;
            send("R7 scalar single AC");
        clean_req(); r.mem = 1; r.packed_f = 0; r.dbl = 1; r.a = 64'h4; r.acen = 1; r.cpl = 3;
            send("R7 scalar double AC");
        clean_req(); r.mem = 1; r.packed_f = 0; r.a = 64'h4; r.acen = 1; r.cpl = 3;
            send("R7 single aligned at 4");
        clean_req(); r.mem = 1; r.packed_f = 0; r.a = 64'h2; r.acen = 1; r.cpl = 0;
            send("R7 cpl0 no AC");
        clean_req(); r.mem = 1; r.packed_f = 0; r.a = 64'h2; r.acen = 0; r.cpl = 3;
            send("R7 disabled no AC");
        clean_req(); r.mode = 2; r.mem = 1; r.packed_f = 0; r.a = 64'h2; r.acen = 1; r.cpl = 0;
            send("R7 v86 forces level 3");
        clean_req(); r.mode = 0; r.mem = 1; r.packed_f = 0; r.a = 64'h2; r.acen = 1; r.cpl = 3;
            send("R7 real forces level 0");
        clean_req(); r.mem = 1; r.packed_f = 0; r.a = 64'h2; r.acen = 1; r.cpl = 3; r.pf = 1;
            send("R9 PF over AC");
        idle(2);
        check(fault_code == last_exp, "R10 hold while idle", int'(fault_code), int'(last_exp));
        check(code_valid == 1'b0, "R10 strobe low idle", int'(code_valid), 0);
        clean_req(); r.fpx = 1; send("R8 numeric XM");
        clean_req(); r.fpx = 1; r.osxmm = 0; send("R8 numeric as UD");
        clean_req(); r.fpx = 1; r.mem = 1; r.packed_f = 0; r.a = 64'h1; r.acen = 1; r.cpl = 3;
            send("R9 AC over numeric");
        clean_req(); r.fpx = 1; r.ts = 1; send("R9 NM over numeric");
        idle(3);
        check(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule